// File: doc/BRIEF.md
# I3C SDR Byte Frame Engine

This block is the data-phase engine of an I3C controller running single-data-rate signalling on a memory-module sideband bus. A transaction sequencer above it handles address arbitration and bus conditions. It hands this engine one byte command at a time. The engine clocks exactly one 9-bit frame, made of eight data bits and a transition bit, and drives SCL itself for the whole frame. For each bit it decides whether the controller actively drives SDA or releases it. It also decides whether the strong open-drain pull-up is switched on.

On a write, the controller keeps SDA in push-pull drive for all nine bits. The ninth bit carries odd parity over the byte. On a read, SDA is released. The target drives the eight data bits while the strong pull-up stays off. For the ninth bit the bus drops to open-drain with the pull-up enabled, and the target reports whether it has more data. The engine returns the byte and that flag. It signals that the read has ended when the target reports no more data. It signals an early termination when the target has more data but the sequencer asked to stop after this byte.

The SCL high and low times come from two count inputs, measured in system clock cycles, so that delay can be stretched to cover a bridging hub. Only single-data-rate framing is ever produced.

Top module: `i3c_sdr_frame_engine`

## Requirements
- R1: While reset is asserted and directly after it is released, scl_o is 0, sda_oe is 0, od_pullup_en is 0, rsp_valid is 0 and cmd_ready is 1.
- R2: The low and high phase lengths are captured when a command is accepted. Within a frame, every SCL low phase lasts cfg_scl_low+1 clock cycles and every SCL high phase lasts cfg_scl_high+1 clock cycles.
- R3: On a write (cmd_read=0), the data bits are presented on sda_o most significant bit first, one per SCL pulse. sda_oe is 1 and od_pullup_en is 0 for all nine bits.
- R4: On a write, the ninth bit driven on sda_o is odd parity: the inverse of the XOR of the eight data bits.
- R5: sda_o, sda_oe and od_pullup_en change only while SCL is low. They hold their values for the whole of each high phase.
- R6: On a read (cmd_read=1), sda_oe is 0 for all nine bits. od_pullup_en is 0 during the eight data bits and 1 during the ninth bit.
- R7: sda_i is sampled at each SCL rising edge. rsp_valid is a single-cycle pulse in the cycle after the ninth high phase ends, which is the cycle in which SCL falls. With that pulse, rsp_rdata carries the eight sampled bits, first sampled bit in bit 7, on a read, and carries 0 on a write.
- R8: With rsp_valid after a read, rsp_more equals the sampled ninth bit and rsp_done equals its inverse. After a write, both are 0.
- R9: rsp_early_term is 1 with rsp_valid only after a read whose ninth bit was 1 and whose command carried cmd_stop_req=1. It is 0 in every other case.
- R10: Each accepted command produces exactly nine SCL pulses. cmd_ready stays 0 from acceptance until the frame ends, and a cmd_valid raised during the frame is ignored.
- R11: Between frames, SCL stays low, SDA is released (sda_oe=0) and od_pullup_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scl_high | input | CNT_W | SCL high time minus one, in clock cycles |
| cfg_scl_low | input | CNT_W | SCL low time minus one, in clock cycles |
| cmd_valid | input | 1 | Command offered by the sequencer |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_read | input | 1 | 1 for a read frame, 0 for a write frame |
| cmd_stop_req | input | 1 | On a read, ask to stop after this byte |
| cmd_wdata | input | DATA_W | Byte to send on a write |
| rsp_valid | output | 1 | One-cycle pulse at frame completion |
| rsp_rdata | output | DATA_W | Byte received on a read |
| rsp_more | output | 1 | Target reported more data |
| rsp_done | output | 1 | Target ended the read |
| rsp_early_term | output | 1 | Read stopped early at the sequencer's request |
| scl_o | output | 1 | Serial clock, always actively driven |
| sda_o | output | 1 | Serial data drive value |
| sda_oe | output | 1 | Serial data drive enable |
| sda_i | input | 1 | Serial data as seen on the bus |
| od_pullup_en | output | 1 | Enable of the strong open-drain pull-up |

## Verification
Several rules are checked by the assertions on every cycle: data-line pins hold still while SCL is high, a write never releases SDA or enables the pull-up, a read never drives SDA, the pull-up is on only while SDA is released, the idle bus is quiet, and the response flags are consistent with the direction and with each other. Other behaviours can only be shown by the bench's scenarios. These are the exact lengths of the SCL phases for each programmed count, the most-significant-first bit order, the parity value, the round trip of read bytes from the modelled target, the nine-pulse frame length, and that a command offered mid-frame never starts a second frame.

// File: rtl/i3c_sdr_pkg.sv
package i3c_sdr_pkg;

   // Bus phase of the frame engine.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   // Pin-level drive bundle.
   typedef struct packed {
      logic scl;
      logic sda_val;
      logic sda_en;
      logic od_pull;
   } pad_t;

endpackage

// File: rtl/sdr_phase_timer.sv
module sdr_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // A phase loaded with N lasts N+1 cycles.
   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_bit_shifter.sv
module sdr_bit_shifter #(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_read,
   input  logic [DATA_W-1:0] start_data,
   input  logic              sample,
   input  logic              advance,
   input  logic              sda_in,
   output logic              is_tbit,
   output logic              tx_bit,
   output logic              rd_mode,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_tbit
);

   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [IDX_W-1:0] TBIT_IDX = IDX_W'(DATA_W);

   logic [DATA_W-1:0] tx_sh_q;
   logic [DATA_W-1:0] rx_sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rd_q;
   logic              par_q;
   logic              tb_q;
   logic              par_in;

   // Parity flavour chosen at elaboration.
   if (ODD_PARITY) begin : g_odd_par
      assign par_in = ~(^start_data);
   end else begin : g_even_par
      assign par_in = ^start_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         idx_q   <= '0;
         rd_q    <= 1'b0;
         par_q   <= 1'b0;
         tb_q    <= 1'b0;
      end else begin
         if (start) begin
            tx_sh_q <= start_data;
            idx_q   <= '0;
            rd_q    <= start_read;
            par_q   <= par_in;
         end else if (advance) begin
            idx_q   <= idx_q + 1'b1;
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
         end
         if (sample && rd_q) begin
            if (is_tbit) begin
               tb_q <= sda_in;
            end else begin
               rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_in};
            end
         end
      end
   end

   assign is_tbit = (idx_q == TBIT_IDX);
   assign tx_bit  = is_tbit ? par_q : tx_sh_q[DATA_W-1];
   assign rd_mode = rd_q;
   assign rx_byte = rx_sh_q;
   assign rx_tbit = tb_q;

endmodule

// File: rtl/sdr_pad_ctrl.sv
module sdr_pad_ctrl
   import i3c_sdr_pkg::*;
(
   input  phase_e phase,
   input  logic   rd_mode,
   input  logic   is_tbit,
   input  logic   tx_bit,
   output pad_t   pad
);

   logic active;

   always_comb begin
      active      = (phase != PH_IDLE);
      pad.scl     = (phase == PH_HIGH);
      // Writes: push-pull for data and parity.
      pad.sda_en  = active & ~rd_mode;
      pad.sda_val = active & ~rd_mode & tx_bit;
      // Reads: released; strong pull-up only for the transition bit.
      pad.od_pull = active & rd_mode & is_tbit;
   end

endmodule

// File: rtl/i3c_sdr_frame_engine.sv
module i3c_sdr_frame_engine
   import i3c_sdr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_scl_high,
   input  logic [CNT_W-1:0]  cfg_scl_low,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_read,
   input  logic              cmd_stop_req,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_more,
   output logic              rsp_done,
   output logic              rsp_early_term,
   output logic              scl_o,
   output logic              sda_o,
   output logic              sda_oe,
   input  logic              sda_i,
   output logic              od_pullup_en
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("CNT_W must be at least 1");
   end

   phase_e            phase_q, phase_d;
   logic [CNT_W-1:0]  hi_q, lo_q;
   logic              stop_q;
   logic              accept;
   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_val;
   logic              smp, adv, frame_end;
   logic              is_tbit, tx_bit, rd_mode, rx_tbit;
   logic [DATA_W-1:0] rx_byte;
   pad_t              pad;

   assign cmd_ready = (phase_q == PH_IDLE);
   assign accept    = cmd_ready & cmd_valid;
   assign smp       = (phase_q == PH_LOW) & tmr_exp;
   assign adv       = (phase_q == PH_HIGH) & tmr_exp & ~is_tbit;
   assign frame_end = (phase_q == PH_HIGH) & tmr_exp & is_tbit;

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = lo_q;
      case (phase_q)
         PH_IDLE: begin
            if (cmd_valid) begin
               phase_d  = PH_LOW;
               tmr_load = 1'b1;
               tmr_val  = cfg_scl_low;
            end
         end
         PH_LOW: begin
            if (tmr_exp) begin
               phase_d  = PH_HIGH;
               tmr_load = 1'b1;
               tmr_val  = hi_q;
            end
         end
         PH_HIGH: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               tmr_val  = lo_q;
               phase_d  = is_tbit ? PH_IDLE : PH_LOW;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         hi_q    <= '0;
         lo_q    <= '0;
         stop_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            hi_q   <= cfg_scl_high;
            lo_q   <= cfg_scl_low;
            stop_q <= cmd_stop_req;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_rdata      <= '0;
         rsp_more       <= 1'b0;
         rsp_done       <= 1'b0;
         rsp_early_term <= 1'b0;
      end else begin
         rsp_valid      <= frame_end;
         rsp_rdata      <= (frame_end & rd_mode) ? rx_byte : '0;
         rsp_more       <= frame_end & rd_mode & rx_tbit;
         rsp_done       <= frame_end & rd_mode & ~rx_tbit;
         rsp_early_term <= frame_end & rd_mode & rx_tbit & stop_q;
      end
   end

   sdr_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   sdr_bit_shifter #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_read (cmd_read),
      .start_data (cmd_wdata),
      .sample     (smp),
      .advance    (adv),
      .sda_in     (sda_i),
      .is_tbit    (is_tbit),
      .tx_bit     (tx_bit),
      .rd_mode    (rd_mode),
      .rx_byte    (rx_byte),
      .rx_tbit    (rx_tbit)
   );

   sdr_pad_ctrl u_pad (
      .phase   (phase_q),
      .rd_mode (rd_mode),
      .is_tbit (is_tbit),
      .tx_bit  (tx_bit),
      .pad     (pad)
   );

   assign scl_o        = pad.scl;
   assign sda_o        = pad.sda_val;
   assign sda_oe       = pad.sda_en;
   assign od_pullup_en = pad.od_pull;

endmodule

// File: rtl/sdr_frame_checker.sv
module sdr_frame_checker (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic cmd_read,
   input logic rsp_valid,
   input logic rsp_more,
   input logic rsp_done,
   input logic rsp_early_term,
   input logic scl_o,
   input logic sda_o,
   input logic sda_oe,
   input logic od_pullup_en
);

   logic rd_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_seen_q <= 1'b0;
      end else if (cmd_valid && cmd_ready) begin
         rd_seen_q <= cmd_read;
      end
   end

   assert_sda_still_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o)) |-> $stable({sda_o, sda_oe, od_pullup_en}));

   assert_write_push_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !rd_seen_q) |-> (sda_oe && !od_pullup_en));

   assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && rd_seen_q) |-> !sda_oe);

   assert_pullup_when_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      od_pullup_en |-> !sda_oe);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!scl_o && !sda_oe && !od_pullup_en));

   assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_write_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rd_seen_q) |-> (!rsp_more && !rsp_done && !rsp_early_term));

   assert_done_inverse_more_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rd_seen_q) |-> (rsp_done == !rsp_more));

   assert_early_needs_more_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_early_term |-> (rsp_valid && rsp_more));

endmodule

bind i3c_sdr_frame_engine sdr_frame_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .cmd_ready      (cmd_ready),
   .cmd_read       (cmd_read),
   .rsp_valid      (rsp_valid),
   .rsp_more       (rsp_more),
   .rsp_done       (rsp_done),
   .rsp_early_term (rsp_early_term),
   .scl_o          (scl_o),
   .sda_o          (sda_o),
   .sda_oe         (sda_oe),
   .od_pullup_en   (od_pullup_en)
);

// File: tb/sim_i3c_sdr_frame_engine.sv
module sim_i3c_sdr_frame_engine;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] cfg_scl_high, cfg_scl_low;
   logic       cmd_valid, cmd_ready, cmd_read, cmd_stop_req;
   logic [7:0] cmd_wdata;
   logic       rsp_valid, rsp_more, rsp_done, rsp_early_term;
   logic [7:0] rsp_rdata;
   logic       scl_o, sda_o, sda_oe, sda_i, od_pullup_en;

   always #2 clk = ~clk;

   i3c_sdr_frame_engine u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_scl_high(cfg_scl_high), .cfg_scl_low(cfg_scl_low),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
      .cmd_stop_req(cmd_stop_req), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_more(rsp_more),
      .rsp_done(rsp_done), .rsp_early_term(rsp_early_term),
      .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i),
      .od_pullup_en(od_pullup_en)
   );

   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Bus monitor and target model.
   bit         mon_on = 1'b0;
   int         lvl, run, nlo, nhi, idx;
   int         lo_run[9];
   int         hi_run[9];
   logic [8:0] got_sda, got_oe, got_pu;
   logic [2:0] prev_pins;
   bit         hi_glitch, ready_busy;
   bit         tgt_rd = 1'b0;
   logic [7:0] tgt_byte;
   logic       tgt_t;

   always @(negedge clk) begin
      if (mon_on) begin
         if (int'(scl_o) == lvl) begin
            run++;
            if (scl_o && {sda_o, sda_oe, od_pullup_en} != prev_pins) hi_glitch = 1'b1;
         end else begin
            if (lvl == 1) begin
               if (nhi < 9) hi_run[nhi] = run;
               nhi++;
            end else begin
               if (nlo < 9) lo_run[nlo] = run;
               nlo++;
            end
            lvl = int'(scl_o);
            run = 1;
            if (scl_o) begin
               if (idx < 9) begin
                  got_sda[8-idx] = sda_o;
                  got_oe[8-idx]  = sda_oe;
                  got_pu[8-idx]  = od_pullup_en;
               end
               idx++;
            end
         end
         prev_pins = {sda_o, sda_oe, od_pullup_en};
         if (!rsp_valid && cmd_ready) ready_busy = 1'b1;
         if (tgt_rd && !scl_o) begin
            if (idx < 8)       sda_i <= tgt_byte[7-idx];
            else if (idx == 8) sda_i <= tgt_t;
            else               sda_i <= 1'b1;
         end
      end
   end

   task automatic frame(input bit rd, input logic [7:0] d, input bit t, input bit ab,
                        input int lo, input int hi, input bit inject);
      int  wait_cnt;
      bit  lo_ok, hi_ok;
      int  lo_bad, hi_bad, rises;
      @(negedge clk);
      cfg_scl_low  = 8'(lo);
      cfg_scl_high = 8'(hi);
      cmd_read     = rd;
      cmd_wdata    = rd ? 8'h00 : d;
      cmd_stop_req = ab;
      tgt_rd       = rd;
      tgt_byte     = d;
      tgt_t        = t;
      sda_i        = rd ? d[7] : 1'b1;
      lvl = 0; run = 0; nlo = 0; nhi = 0; idx = 0;
      got_sda = '0; got_oe = '0; got_pu = '0; prev_pins = '0;
      hi_glitch = 1'b0; ready_busy = 1'b0;
      cmd_valid = 1'b1;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      mon_on    = 1'b1;
      if (inject) begin
         repeat (3) @(negedge clk);
         cmd_valid = 1'b1;
         cmd_wdata = ~d;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      wait_cnt = 0;
      do begin
         @(negedge clk);
         wait_cnt++;
      end while (!rsp_valid && wait_cnt < 10000);
      #1;
      mon_on = 1'b0;
      tgt_rd = 1'b0;

      lo_ok = (nlo == 9); hi_ok = (nhi == 9);
      lo_bad = nlo; hi_bad = nhi;
      for (int k = 0; k < 9; k++) begin
         if (lo_run[k] != lo + 1 && lo_ok) begin lo_ok = 1'b0; lo_bad = lo_run[k]; end
         if (hi_run[k] != hi + 1 && hi_ok) begin hi_ok = 1'b0; hi_bad = hi_run[k]; end
      end
      chk(lo_ok, "R2 low phase length", lo_ok ? lo + 1 : lo_bad, lo + 1);
      chk(hi_ok, "R2 high phase length", hi_ok ? hi + 1 : hi_bad, hi + 1);
      chk(rsp_valid, "R7 response pulse timing", int'(rsp_valid), 1);
      chk(idx == 9, "R10 nine SCL pulses", idx, 9);
      chk(!ready_busy, "R10 ready low while busy", int'(ready_busy), 0);
      chk(!hi_glitch, "R5 SDA still during SCL high", int'(hi_glitch), 0);
      if (!rd) begin
         chk(got_sda[8:1] == d, "R3 write bits MSB first", int'(got_sda[8:1]), int'(d));
         chk(got_sda[0] == ~(^d), "R4 odd parity T-bit", int'(got_sda[0]), int'(~(^d)));
         chk(got_oe == 9'h1FF && got_pu == 9'h000, "R3 push-pull on write",
             int'({got_oe, got_pu}), int'({9'h1FF, 9'h000}));
         chk(rsp_rdata == 8'h00 && !rsp_more && !rsp_done && !rsp_early_term,
             "R8 write response clear", int'({rsp_rdata, rsp_more, rsp_done, rsp_early_term}), 0);
      end else begin
         chk(got_oe == 9'h000 && got_pu == 9'h001, "R6 release and T-bit pull-up",
             int'({got_oe, got_pu}), int'({9'h000, 9'h001}));
         chk(rsp_rdata == d, "R7 read byte", int'(rsp_rdata), int'(d));
         chk(rsp_more == t && rsp_done == !t, "R8 more/done flags",
             int'({rsp_more, rsp_done}), int'({t, !t}));
         chk(rsp_early_term == (t & ab), "R9 early terminate",
             int'(rsp_early_term), int'(t & ab));
      end
      @(negedge clk);
      chk(!scl_o && !sda_oe && !od_pullup_en && cmd_ready && !rsp_valid, "R11 idle bus",
          int'({scl_o, sda_oe, od_pullup_en, cmd_ready, rsp_valid}), int'(5'b00010));
      sda_i = 1'b1;
      if (inject) begin
         rises = 0;
         repeat (30) begin
            @(negedge clk);
            if (scl_o) rises++;
         end
         chk(rises == 0, "R10 mid-frame command ignored", rises, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_stop_req = 1'b0;
      cmd_wdata = '0; cfg_scl_high = '0; cfg_scl_low = '0; sda_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(!scl_o && !sda_oe && !od_pullup_en && !rsp_valid && cmd_ready, "R1 in reset",
          int'({scl_o, sda_oe, od_pullup_en, rsp_valid, cmd_ready}), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!scl_o && !sda_oe && !od_pullup_en && !rsp_valid && cmd_ready, "R1 after reset",
          int'({scl_o, sda_oe, od_pullup_en, rsp_valid, cmd_ready}), 1);

      // Timing sweep over small phase counts.
      for (int lo = 0; lo < 4; lo++) begin
         for (int hi = 0; hi < 4; hi++) begin
            for (int k = 0; k < 4; k++) begin
               frame(1'b0, 8'((lo * 16 + hi) * 37 + k * 91), 1'b0, 1'b0, lo, hi, 1'b0);
               frame(1'b1, 8'((lo * 16 + hi) * 53 + k * 29), k[0], k[1], lo, hi, 1'b0);
            end
         end
      end
      // Exhaustive byte values at short timing.
      for (int b = 0; b < 256; b++) frame(1'b0, 8'(b), 1'b0, 1'b0, 0, 0, 1'b0);
      for (int b = 0; b < 256; b++) frame(1'b1, 8'(b), b[0], b[1], 1, 0, 1'b0);
      // Widest counts and a command offered mid-frame.
      frame(1'b0, 8'h96, 1'b0, 1'b0, 255, 255, 1'b0);
      frame(1'b1, 8'h69, 1'b1, 1'b1, 255, 255, 1'b0);
      frame(1'b0, 8'hC3, 1'b0, 1'b0, 2, 1, 1'b1);
      frame(1'b1, 8'h3C, 1'b1, 1'b0, 1, 2, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule